// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits between a host write port and a parallel NOR flash array model. It reads each host write as a word of a command protocol rather than as data. Writes made while idle are commands that pick a read mode or open an operation. Each operation then takes one further write that supplies the data, the target address or a confirmation code. The block keeps an 8-bit status register with the ready bit always set, and one lock bit for each 64 KiB erase block. It also tracks how full the buffered-program window is.

The block does not hold the array or the program buffer. It sends single-cycle requests to separate storage blocks: store one word, erase one block, write a word into the program buffer, clear the buffer, or commit it. A lock bit on the target block suppresses the request and records an error in status. The read-data multiplexer downstream uses the read-mode output to choose between array data, status, identification and query data.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset the read mode is ARRAY (code 0), status is 0x80, every lock bit is clear and no request output is active. The read mode codes are ARRAY=0, STATUS=1, IDENT=2, QUERY=3.
- R2: While idle, the low byte of a write is a command and the address is ignored. 0x90 selects IDENT, 0x70 selects STATUS, 0x98 selects QUERY, and 0xFF or any unlisted byte selects ARRAY. A stray 0xD0 changes nothing.
- R3: An idle write of 0x50 restores status to 0x80. Status bit 7 is always 1.
- R4: An idle write of 0x40 or 0x10 arms word program and selects STATUS. The next write raises progReq for one cycle with its address, its data and its byte enables (01 for a 1-byte access, 11 for 2 or 4 bytes), then returns to idle.
- R5: An idle write of 0x60 arms lock setup and leaves the read mode unchanged. The next write then acts by its value. 0x01 sets the lock bit of block address/65536. 0xD0 clears that bit. Either of these selects STATUS. Any other value ORs 0x30 into status and leaves the read mode as it was. In every case the block returns to idle.
- R6: A program, erase or commit whose target block is locked issues no request and ORs 0x12 into status.
- R7: An idle write of 0x20 arms erase and selects STATUS. A following 0xD0 raises eraseReq with block index address/65536. Any other value ORs 0x30 into status. Both return to idle.
- R8: An idle write of 0xE8 pulses bufClr and selects STATUS. The next write N sets the buffer length to the smaller of (N+1)*4 and 128 bytes.
- R9: The first buffer write fixes the base address. A write is accepted, and raises bufWrReq with offset address minus base, only while the bytes already taken are fewer than the length, the address is not below the base, and the offset is below 128. Each accepted write adds its access size to the byte count.
- R10: A rejected buffer write of 0xD0 raises commitReq with the base and the byte count. A rejected write of any other value ORs 0x10 into status. Both return to idle.
- R11: A write wider than 4 bytes has no effect on state, read mode, status, locks or requests.
- R12: Each request is a one-cycle pulse that appears on the clock after the write that caused it. At most one request is active in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe, one cycle per access |
| wrAddr | input | ADDR_W (19) | Byte address of the access |
| wrData | input | 16 | Command or data word |
| wrSize | input | 4 | Access size in bytes |
| readMode | output | 2 | Current read mode code |
| statusReg | output | 8 | Status register |
| lockState | output | NUM_BLOCKS (8) | Lock bit per erase block |
| progReq | output | 1 | Word program request pulse |
| progAddr | output | ADDR_W (19) | Program address |
| progData | output | 16 | Program data |
| progBe | output | 2 | Program byte enables |
| eraseReq | output | 1 | Block erase request pulse |
| eraseBlk | output | BLK_W (3) | Block to fill with 0xFF |
| bufClr | output | 1 | Program buffer clear pulse |
| bufWrReq | output | 1 | Buffer store pulse |
| bufWrOff | output | OFF_W (7) | Byte offset in the buffer |
| bufWrData | output | 16 | Buffer store data |
| bufWrBe | output | 2 | Buffer store byte enables |
| commitReq | output | 1 | Buffer commit pulse |
| commitBase | output | ADDR_W (19) | Array address of buffer byte 0 |
| commitLen | output | CNT_W (9) | Bytes to commit |

## Verification
The bench checks the buffered-program boundaries. A write past the negotiated length, one below the base and one at offset 128 must each be rejected. A faulty acceptance test would store past the window or commit a wrong count. A written length of 100 must cap to 128, or the offset 0x7E write would be refused. Locked blocks are driven through program, erase and commit. A design that skipped the lock check would issue the request and leave status at 0x80. Illegal confirmation bytes in lock and erase setup must OR 0x30, while one in a buffer fill must OR 0x10, so swapping the two error codes is caught. Wide writes fed while an operation is armed must leave it armed. A design that consumed them would not program on the next narrow write.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOCK,
    ST_PROG,
    ST_BSETUP,
    ST_BFILL,
    ST_ERASE
  } op_state_e;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_IDENT  = 2'd2,
    RM_QUERY  = 2'd3
  } read_mode_e;

  localparam logic [7:0] OP_LOCK_SET   = 8'h01;
  localparam logic [7:0] OP_PROG_ALT   = 8'h10;
  localparam logic [7:0] OP_ERASE      = 8'h20;
  localparam logic [7:0] OP_PROG       = 8'h40;
  localparam logic [7:0] OP_CLRSTAT    = 8'h50;
  localparam logic [7:0] OP_LOCK_SETUP = 8'h60;
  localparam logic [7:0] OP_STATUS     = 8'h70;
  localparam logic [7:0] OP_IDENT      = 8'h90;
  localparam logic [7:0] OP_QUERY      = 8'h98;
  localparam logic [7:0] OP_CONFIRM    = 8'hD0;
  localparam logic [7:0] OP_BUF_SETUP  = 8'hE8;

  localparam logic [7:0] STAT_READY   = 8'h80;
  localparam logic [7:0] ERR_LOCKED   = 8'h12;
  localparam logic [7:0] ERR_SEQUENCE = 8'h30;
  localparam logic [7:0] ERR_BUFFER   = 8'h10;

  typedef struct packed {
    logic       clrStatus;
    logic [7:0] orStatus;
    logic       lockSet;
    logic       lockClr;
    logic       bufReset;
    logic       bufStore;
    logic       setLen;
    logic       doProg;
    logic       doErase;
    logic       doCommit;
  } dp_ctrl_t;

endpackage

// File: rtl/nor_cmd_ctrl_fsm.sv
module nor_cmd_ctrl_fsm
  import nor_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic       sizeOk,
  input  logic [7:0] cmdByte,
  input  logic       blkLocked,
  input  logic       baseLocked,
  input  logic       bufAccept,
  output logic [1:0] readMode,
  output dp_ctrl_t   ctl
);

  op_state_e  stateQ, nxtState;
  read_mode_e modeQ, nxtMode;

  always_comb begin
    nxtState = stateQ;
    nxtMode  = modeQ;
    ctl      = '0;
    if (wrEn && sizeOk) begin
      unique case (stateQ)
        ST_IDLE: begin
          case (cmdByte)
            OP_IDENT:  nxtMode = RM_IDENT;
            OP_STATUS: nxtMode = RM_STATUS;
            OP_QUERY:  nxtMode = RM_QUERY;
            OP_CLRSTAT: ctl.clrStatus = 1'b1;
            OP_PROG, OP_PROG_ALT: begin
              nxtState = ST_PROG;
              nxtMode  = RM_STATUS;
            end
            OP_LOCK_SETUP: nxtState = ST_LOCK;
            OP_ERASE: begin
              nxtState = ST_ERASE;
              nxtMode  = RM_STATUS;
            end
            OP_BUF_SETUP: begin
              ctl.bufReset = 1'b1;
              nxtState     = ST_BSETUP;
              nxtMode      = RM_STATUS;
            end
            OP_CONFIRM: ;
            default: nxtMode = RM_ARRAY;
          endcase
        end
        ST_LOCK: begin
          if (cmdByte == OP_LOCK_SET) begin
            ctl.lockSet = 1'b1;
            nxtMode     = RM_STATUS;
          end else if (cmdByte == OP_CONFIRM) begin
            ctl.lockClr = 1'b1;
            nxtMode     = RM_STATUS;
          end else begin
            ctl.orStatus = ERR_SEQUENCE;
          end
          nxtState = ST_IDLE;
        end
        ST_PROG: begin
          if (blkLocked) ctl.orStatus = ERR_LOCKED;
          else           ctl.doProg   = 1'b1;
          nxtMode  = RM_STATUS;
          nxtState = ST_IDLE;
        end
        ST_ERASE: begin
          if (cmdByte == OP_CONFIRM) begin
            if (blkLocked) ctl.orStatus = ERR_LOCKED;
            else           ctl.doErase  = 1'b1;
          end else begin
            ctl.orStatus = ERR_SEQUENCE;
          end
          nxtMode  = RM_STATUS;
          nxtState = ST_IDLE;
        end
        ST_BSETUP: begin
          ctl.setLen = 1'b1;
          nxtState   = ST_BFILL;
          nxtMode    = RM_STATUS;
        end
        ST_BFILL: begin
          if (bufAccept) begin
            ctl.bufStore = 1'b1;
          end else begin
            if (cmdByte == OP_CONFIRM) begin
              if (baseLocked) ctl.orStatus = ERR_LOCKED;
              else            ctl.doCommit = 1'b1;
              nxtMode = RM_STATUS;
            end else begin
              ctl.orStatus = ERR_BUFFER;
            end
            nxtState = ST_IDLE;
          end
        end
        default: nxtState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      modeQ  <= RM_ARRAY;
    end else begin
      stateQ <= nxtState;
      modeQ  <= nxtMode;
    end
  end

  assign readMode = modeQ;

endmodule

// File: rtl/nor_cmd_ctrl_dp.sv
module nor_cmd_ctrl_dp
  import nor_cmd_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int BUF_BYTES  = 128,
  parameter int BLK_W      = 3,
  parameter int ADDR_W     = 19,
  parameter int OFF_W      = 7,
  parameter int CNT_W      = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  dp_ctrl_t              ctl,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [15:0]           wrData,
  input  logic [3:0]            wrSize,
  output logic                  sizeOk,
  output logic                  blkLocked,
  output logic                  baseLocked,
  output logic                  bufAccept,
  output logic [7:0]            statusReg,
  output logic [NUM_BLOCKS-1:0] lockState,
  output logic                  progReq,
  output logic [ADDR_W-1:0]     progAddr,
  output logic [15:0]           progData,
  output logic [1:0]            progBe,
  output logic                  eraseReq,
  output logic [BLK_W-1:0]      eraseBlk,
  output logic                  bufClr,
  output logic                  bufWrReq,
  output logic [OFF_W-1:0]      bufWrOff,
  output logic [15:0]           bufWrData,
  output logic [1:0]            bufWrBe,
  output logic                  commitReq,
  output logic [ADDR_W-1:0]     commitBase,
  output logic [CNT_W-1:0]      commitLen
);

  localparam int LEN_W = CNT_W - 1;
  localparam int PROD_W = 19;
  localparam logic [PROD_W-1:0] LEN_CAP = PROD_W'(BUF_BYTES);

  logic [7:0]            statusQ;
  logic [NUM_BLOCKS-1:0] lockQ;
  logic [CNT_W-1:0]      countQ;
  logic [LEN_W-1:0]      lenQ;
  logic [ADDR_W-1:0]     baseQ;
  logic                  baseValid;

  logic [BLK_W-1:0]  wrBlk, baseBlk;
  logic [ADDR_W-1:0] effBase, offFull;
  logic [1:0]        byteEn;
  logic [PROD_W-1:0] lenProd;

  assign sizeOk  = (wrSize != 4'd0) && (wrSize <= 4'd4);
  assign byteEn  = (wrSize == 4'd1) ? 2'b01 : 2'b11;
  assign wrBlk   = wrAddr[ADDR_W-1:16];
  assign baseBlk = baseQ[ADDR_W-1:16];

  assign blkLocked  = lockQ[wrBlk];
  assign baseLocked = lockQ[baseBlk];

  // buffer window test
  assign effBase   = baseValid ? baseQ : wrAddr;
  assign offFull   = wrAddr - effBase;
  assign bufAccept = (countQ < CNT_W'(lenQ)) && (wrAddr >= effBase) &&
                     (offFull < ADDR_W'(BUF_BYTES));

  assign lenProd = (PROD_W'(wrData) + PROD_W'(1)) << 2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statusQ <= STAT_READY;
    end else if (ctl.clrStatus) begin
      statusQ <= STAT_READY;
    end else begin
      statusQ <= statusQ | ctl.orStatus;
    end
  end

  // one lock cell per erase block
  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_lock
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lockQ[g] <= 1'b0;
      end else if (wrBlk == BLK_W'(g)) begin
        if (ctl.lockSet)      lockQ[g] <= 1'b1;
        else if (ctl.lockClr) lockQ[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      countQ    <= '0;
      lenQ      <= '0;
      baseQ     <= '0;
      baseValid <= 1'b0;
    end else begin
      if (ctl.bufReset) begin
        countQ    <= '0;
        baseValid <= 1'b0;
      end
      if (ctl.setLen) begin
        lenQ <= (lenProd > LEN_CAP) ? LEN_W'(BUF_BYTES) : LEN_W'(lenProd);
      end
      if (ctl.bufStore) begin
        countQ <= countQ + CNT_W'(wrSize);
        if (!baseValid) begin
          baseQ     <= wrAddr;
          baseValid <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      progReq    <= 1'b0;
      progAddr   <= '0;
      progData   <= '0;
      progBe     <= '0;
      eraseReq   <= 1'b0;
      eraseBlk   <= '0;
      bufClr     <= 1'b0;
      bufWrReq   <= 1'b0;
      bufWrOff   <= '0;
      bufWrData  <= '0;
      bufWrBe    <= '0;
      commitReq  <= 1'b0;
      commitBase <= '0;
      commitLen  <= '0;
    end else begin
      progReq    <= ctl.doProg;
      progAddr   <= wrAddr;
      progData   <= wrData;
      progBe     <= byteEn;
      eraseReq   <= ctl.doErase;
      eraseBlk   <= wrBlk;
      bufClr     <= ctl.bufReset;
      bufWrReq   <= ctl.bufStore;
      bufWrOff   <= offFull[OFF_W-1:0];
      bufWrData  <= wrData;
      bufWrBe    <= byteEn;
      commitReq  <= ctl.doCommit;
      commitBase <= baseQ;
      commitLen  <= countQ;
    end
  end

  assign statusReg = statusQ;
  assign lockState = lockQ;

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_cmd_pkg::*;
#(
  parameter  int NUM_BLOCKS = 8,
  parameter  int BUF_BYTES  = 128,
  localparam int BLK_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int ADDR_W     = 16 + BLK_W,
  localparam int OFF_W      = $clog2(BUF_BYTES),
  localparam int CNT_W      = $clog2(BUF_BYTES) + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [15:0]           wrData,
  input  logic [3:0]            wrSize,
  output logic [1:0]            readMode,
  output logic [7:0]            statusReg,
  output logic [NUM_BLOCKS-1:0] lockState,
  output logic                  progReq,
  output logic [ADDR_W-1:0]     progAddr,
  output logic [15:0]           progData,
  output logic [1:0]            progBe,
  output logic                  eraseReq,
  output logic [BLK_W-1:0]      eraseBlk,
  output logic                  bufClr,
  output logic                  bufWrReq,
  output logic [OFF_W-1:0]      bufWrOff,
  output logic [15:0]           bufWrData,
  output logic [1:0]            bufWrBe,
  output logic                  commitReq,
  output logic [ADDR_W-1:0]     commitBase,
  output logic [CNT_W-1:0]      commitLen
);

  dp_ctrl_t ctl;
  logic     sizeOk, blkLocked, baseLocked, bufAccept;

  nor_cmd_ctrl_fsm fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrEn       (wrEn),
    .sizeOk     (sizeOk),
    .cmdByte    (wrData[7:0]),
    .blkLocked  (blkLocked),
    .baseLocked (baseLocked),
    .bufAccept  (bufAccept),
    .readMode   (readMode),
    .ctl        (ctl)
  );

  nor_cmd_ctrl_dp #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .BUF_BYTES  (BUF_BYTES),
    .BLK_W      (BLK_W),
    .ADDR_W     (ADDR_W),
    .OFF_W      (OFF_W),
    .CNT_W      (CNT_W)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .wrSize     (wrSize),
    .sizeOk     (sizeOk),
    .blkLocked  (blkLocked),
    .baseLocked (baseLocked),
    .bufAccept  (bufAccept),
    .statusReg  (statusReg),
    .lockState  (lockState),
    .progReq    (progReq),
    .progAddr   (progAddr),
    .progData   (progData),
    .progBe     (progBe),
    .eraseReq   (eraseReq),
    .eraseBlk   (eraseBlk),
    .bufClr     (bufClr),
    .bufWrReq   (bufWrReq),
    .bufWrOff   (bufWrOff),
    .bufWrData  (bufWrData),
    .bufWrBe    (bufWrBe),
    .commitReq  (commitReq),
    .commitBase (commitBase),
    .commitLen  (commitLen)
  );

endmodule

// File: rtl/nor_cmd_ctrl_chk.sv
module nor_cmd_ctrl_chk #(
  parameter int NUM_BLOCKS = 8,
  parameter int BLK_W      = 3,
  parameter int ADDR_W     = 19
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wrEn,
  input logic [3:0]            wrSize,
  input logic [1:0]            readMode,
  input logic [7:0]            statusReg,
  input logic [NUM_BLOCKS-1:0] lockState,
  input logic                  progReq,
  input logic [ADDR_W-1:0]     progAddr,
  input logic                  eraseReq,
  input logic [BLK_W-1:0]      eraseBlk,
  input logic                  bufClr,
  input logic                  bufWrReq,
  input logic                  commitReq
);

  logic anyReq;
  assign anyReq = progReq | eraseReq | bufClr | bufWrReq | commitReq;

  // R12
  a_r12_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({progReq, eraseReq, bufClr, bufWrReq, commitReq}));

  // R12
  a_r12_request_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    anyReq |-> $past(wrEn));

  // R3
  a_r3_ready_bit: assert property (@(posedge clk) disable iff (!rst_n)
    statusReg[7]);

  // R6
  a_r6_prog_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    progReq |-> !lockState[progAddr[ADDR_W-1:16]]);

  // R6 / R7
  a_r7_erase_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    eraseReq |-> !lockState[eraseBlk]);

  // R5
  a_r5_lock_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lockState) |-> $past(wrEn));

  // R11
  a_r11_wide_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrSize > 4'd4) |=> ($stable(statusReg) && $stable(lockState) &&
                                 $stable(readMode) && !anyReq));

endmodule

bind nor_cmd_ctrl nor_cmd_ctrl_chk #(
  .NUM_BLOCKS (NUM_BLOCKS),
  .BLK_W      (BLK_W),
  .ADDR_W     (ADDR_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wrEn      (wrEn),
  .wrSize    (wrSize),
  .readMode  (readMode),
  .statusReg (statusReg),
  .lockState (lockState),
  .progReq   (progReq),
  .progAddr  (progAddr),
  .eraseReq  (eraseReq),
  .eraseBlk  (eraseBlk),
  .bufClr    (bufClr),
  .bufWrReq  (bufWrReq),
  .commitReq (commitReq)
);

// File: tb/nor_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module nor_cmd_ctrl_tb_top;

  localparam int NUM_BLOCKS = 8;
  localparam int ADDR_W = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [3:0] wrSize = 4'd2;

  logic [1:0] readMode;
  logic [7:0] statusReg;
  logic [NUM_BLOCKS-1:0] lockState;
  logic progReq, eraseReq, bufClr, bufWrReq, commitReq;
  logic [ADDR_W-1:0] progAddr, commitBase;
  logic [15:0] progData, bufWrData;
  logic [1:0] progBe, bufWrBe;
  logic [2:0] eraseBlk;
  logic [6:0] bufWrOff;
  logic [8:0] commitLen;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nor_cmd_ctrl #(.NUM_BLOCKS(NUM_BLOCKS), .BUF_BYTES(128)) dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrSize(wrSize), .readMode(readMode), .statusReg(statusReg),
    .lockState(lockState), .progReq(progReq), .progAddr(progAddr),
    .progData(progData), .progBe(progBe), .eraseReq(eraseReq),
    .eraseBlk(eraseBlk), .bufClr(bufClr), .bufWrReq(bufWrReq),
    .bufWrOff(bufWrOff), .bufWrData(bufWrData), .bufWrBe(bufWrBe),
    .commitReq(commitReq), .commitBase(commitBase), .commitLen(commitLen)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one write; returns at the falling edge after the capturing edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                    input logic [3:0] s = 4'd2);
    @(negedge clk);
    wrAddr = a; wrData = d; wrSize = s; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic int reqVec();
    return {27'd0, progReq, eraseReq, bufClr, bufWrReq, commitReq};
  endfunction

  task automatic t_reset();
    chk("R1 read mode", readMode, 0);
    chk("R1 status", statusReg, 8'h80);
    chk("R1 locks", lockState, 0);
    chk("R1 requests", reqVec(), 0);
  endtask

  task automatic t_modes();
    wr(19'h1234, 16'h0090); chk("R2 ident mode", readMode, 2);
    wr(19'h0, 16'h0098);    chk("R2 query mode", readMode, 3);
    wr(19'h7, 16'h0070);    chk("R2 status mode", readMode, 1);
    wr(19'h0, 16'h00FF);    chk("R2 array mode", readMode, 0);
    wr(19'h0, 16'h0070);
    wr(19'h0, 16'h0033);    chk("R2 unknown to array", readMode, 0);
    wr(19'h0, 16'h0070);
    wr(19'h0, 16'h00D0);    chk("R2 stray confirm mode", readMode, 1);
    chk("R2 stray confirm status", statusReg, 8'h80);
    chk("R2 stray confirm no request", reqVec(), 0);
  endtask

  task automatic t_prog();
    wr(19'h0, 16'h00FF);
    wr(19'h0, 16'h0040);    chk("R4 mode after arm", readMode, 1);
    chk("R4 no early request", progReq, 0);
    wr(19'h12346, 16'hBEEF, 4'd2);
    chk("R4 progReq", progReq, 1);
    chk("R4 progAddr", progAddr, 19'h12346);
    chk("R4 progData", progData, 16'hBEEF);
    chk("R4 progBe", progBe, 2'b11);
    @(negedge clk);
    chk("R12 pulse width", progReq, 0);
    wr(19'h0, 16'h0010);
    wr(19'h00005, 16'h00A5, 4'd1);
    chk("R4 alt opcode req", progReq, 1);
    chk("R4 byte enable 1 byte", progBe, 2'b01);
    wr(19'h0, 16'h0090);    chk("R4 back to idle", readMode, 2);
  endtask

  task automatic t_lock();
    wr(19'h0, 16'h00FF);
    wr(19'h0, 16'h0060);    chk("R5 arm keeps mode", readMode, 0);
    wr(19'h30000, 16'h0001);
    chk("R5 lock set", lockState, 8'h08);
    chk("R5 mode status", readMode, 1);
    wr(19'h0, 16'h0040);
    wr(19'h30010, 16'h1234);
    chk("R6 program blocked", progReq, 0);
    chk("R6 program lock status", statusReg, 8'h92);
    wr(19'h0, 16'h0050);    chk("R3 clear status", statusReg, 8'h80);
    wr(19'h0, 16'h0020);
    wr(19'h3FFFE, 16'h00D0);
    chk("R6 erase blocked", eraseReq, 0);
    chk("R6 erase lock status", statusReg, 8'h92);
    wr(19'h0, 16'h0050);
    wr(19'h0, 16'h0060);
    wr(19'h30000, 16'h00D0);
    chk("R5 unlock", lockState, 0);
    wr(19'h0, 16'h00FF);
    wr(19'h0, 16'h0060);
    wr(19'h30000, 16'h0077);
    chk("R5 bad lock code status", statusReg, 8'hB0);
    chk("R5 bad lock code mode", readMode, 0);
    chk("R5 bad lock code locks", lockState, 0);
    wr(19'h0, 16'h0050);
  endtask

  task automatic t_erase();
    wr(19'h0, 16'h00FF);
    wr(19'h0, 16'h0020);    chk("R7 mode after arm", readMode, 1);
    wr(19'h52345, 16'h00D0);
    chk("R7 eraseReq", eraseReq, 1);
    chk("R7 erase block", eraseBlk, 5);
    wr(19'h0, 16'h0020);
    wr(19'h0, 16'h0055);
    chk("R7 bad confirm no erase", eraseReq, 0);
    chk("R7 bad confirm status", statusReg, 8'hB0);
    wr(19'h0, 16'h0050);
  endtask

  task automatic t_buffer();
    wr(19'h0, 16'h00FF);
    wr(19'h0, 16'h00E8);
    chk("R8 bufClr", bufClr, 1);
    chk("R8 mode", readMode, 1);
    wr(19'h0, 16'h0001);      // length 8
    chk("R8 length write no store", bufWrReq, 0);
    wr(19'h20100, 16'hAAAA, 4'd2);
    chk("R9 first store", bufWrReq, 1);
    chk("R9 first offset", bufWrOff, 0);
    chk("R9 store data", bufWrData, 16'hAAAA);
    wr(19'h20102, 16'hBBBB, 4'd2);
    chk("R9 second offset", bufWrOff, 2);
    wr(19'h20104, 16'hCCCC, 4'd4);
    chk("R9 third store", bufWrReq, 1);
    chk("R9 third offset", bufWrOff, 4);
    wr(19'h20108, 16'h00D0, 4'd2);
    chk("R9 full rejects store", bufWrReq, 0);
    chk("R10 commitReq", commitReq, 1);
    chk("R10 commit base", commitBase, 19'h20100);
    chk("R10 commit length", commitLen, 8);
    wr(19'h0, 16'h0098);
    chk("R10 idle after commit", readMode, 3);

    // length cap and below-base reject
    wr(19'h0, 16'h00E8);
    wr(19'h0, 16'd100);       // capped to 128
    wr(19'h40080, 16'h0101, 4'd2);
    wr(19'h400FE, 16'h0202, 4'd2);
    chk("R8 cap keeps offset 0x7E", bufWrReq, 1);
    chk("R8 offset 0x7E", bufWrOff, 7'h7E);
    wr(19'h40000, 16'h00D0, 4'd2);
    chk("R9 below base rejected", bufWrReq, 0);
    chk("R10 commit after below-base", commitReq, 1);
    chk("R10 commit base 2", commitBase, 19'h40080);
    chk("R10 commit length 2", commitLen, 4);

    // offset 128 reject with non-confirm
    wr(19'h0, 16'h00E8);
    wr(19'h0, 16'h0003);
    wr(19'h40000, 16'h1111, 4'd2);
    wr(19'h40080, 16'h0012, 4'd2);
    chk("R9 offset 128 rejected", bufWrReq, 0);
    chk("R10 no commit", commitReq, 0);
    chk("R10 buffer error status", statusReg, 8'h90);
    wr(19'h0, 16'h0050);

    // locked base block
    wr(19'h0, 16'h0060);
    wr(19'h60000, 16'h0001);
    wr(19'h0, 16'h00E8);
    wr(19'h0, 16'h0000);
    wr(19'h60000, 16'h5555, 4'd2);
    wr(19'h70000, 16'h00D0, 4'd2);
    chk("R6 commit blocked", commitReq, 0);
    chk("R6 commit lock status", statusReg, 8'h92);
    wr(19'h0, 16'h0050);
  endtask

  task automatic t_wide();
    wr(19'h0, 16'h00FF);
    wr(19'h0, 16'h0070, 4'd8);
    chk("R11 wide command ignored", readMode, 0);
    wr(19'h0, 16'h0040);
    wr(19'h10000, 16'hABCD, 4'd8);
    chk("R11 wide data no program", progReq, 0);
    chk("R11 status unchanged", statusReg, 8'h80);
    wr(19'h10002, 16'h1357, 4'd2);
    chk("R11 program still armed", progReq, 1);
    chk("R11 program addr", progAddr, 19'h10002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_prog();
    t_lock();
    t_erase();
    t_buffer();
    t_wide();
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule